// File: doc/BRIEF.md
# Sticky Fault Status Capture Unit

This block records asynchronous memory and bus error events for a processor-side error handler. Each error event arrives as a one-cycle pulse with a class code. Alongside it come the faulting transaction address, a 4-bit memory-tag syndrome, a 9-bit data syndrome, the current privilege level and the 16-byte beat position within a 64-byte transaction. The event sets a sticky bit in a 64-bit status word. The block also tracks repeated errors of one class in a multiple-error flag and copies the privilege level.

A single fault-address register and the two syndrome fields record the details of one event only. They hold the highest-priority event that is still pending. A more severe event replaces the held details. Once software clears the status bit of the held event, the registers accept new details, even if other status bits remain set. Software reads and clears the status word through a small register port. A fatal-error output and a gated interrupt request report the pending errors to the rest of the chip.

Top module: `fault_status_log`

## Requirements
- R1: An accepted error with class code k (0 to 18) sets status bit 33+k. That bit stays set until a register write to address 0 carries a 1 in its position. A 0 in a written position leaves the bit unchanged. Bits 53:33 are the bits that software can clear this way.
- R2: Reading the status word through the register port never changes any bit.
- R3: Bit 53 sets when an accepted error finds its own status bit already set and its class is not hardware-corrected. The class groups are:
  - fatal: codes 17 and 18
  - software-correctable: code 9
  - hardware-corrected: codes 0, 3, 5, 7, 13 and 15
  - uncorrectable: all other codes

  A repeated hardware-corrected error never sets bit 53.
- R4: A `txn_start` pulse opens a new transaction. Within one transaction, the first accepted ECC-flagged error fixes a beat position. A later ECC-flagged error with a higher beat is dropped completely: no status bit, no bit 53, no capture. The next `txn_start` removes this restriction.
- R5: Each accepted error copies `err_priv` into bit 52.
- R6: The address register and the syndrome fields capture an accepted error in either of two cases: nothing is held, or the new error ranks strictly higher than the held one. The ranks, from highest to lowest, are fatal, uncorrectable, software-correctable and hardware-corrected. An error of equal or lower rank leaves the held values unchanged.
- R7: Clearing the status bit of the held event unlocks capture, even when other status bits stay set. The held values remain readable until the next capture.
- R8: The memory-tag syndrome is read at status bits 19:16 and the data syndrome at bits 8:0. Writes cannot change either field. Register address 1 returns the fault address, zero-extended, and writes to it are ignored.
- R9: `fatal_err` is high exactly while status bit 51 or bit 50 is set.
- R10: `irq` is high exactly while `irq_en` is high and any of status bits 50:33 is set.
- R11: When a new error and a software clear hit the same bit in the same cycle, the bit stays set. Capture then follows R6 and R7 as though the clear came first.
- R12: After reset, both registers read zero and `irq` and `fatal_err` are low. Class codes above 18 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | One-cycle error event pulse |
| err_class | input | 5 | Error class code |
| err_ecc | input | 1 | Event is an ECC error subject to the beat filter |
| err_beat | input | BEAT_W | 16-byte subunit position within the transaction |
| txn_start | input | 1 | First beat of a new 64-byte transaction |
| err_addr | input | ADDR_W | Faulting transaction address |
| err_msyn | input | 4 | Memory-tag syndrome |
| err_dsyn | input | 9 | Data syndrome |
| err_priv | input | 1 | Privilege level at detection |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status word, 1 = fault address |
| reg_wdata | input | 64 | Write data (write-1-to-clear on status) |
| reg_rdata | output | 64 | Read data for the selected register |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| fatal_err | output | 1 | Fatal error indication |

## Verification
The bench targets four corner cases:
- Capture ownership. An uncorrectable error arrives while a corrected one is held, an equal-rank repeat follows, and then only the held event's bit is cleared. A design with an inverted or non-strict priority compare, or one that unlocks only when every bit is clear, shows the wrong fault address.
- The transaction filter. An error in a later beat of the same transaction must leave the status word untouched, while the same error after a new `txn_start` is logged. A missing filter sets an extra bit or the multiple-error flag.
- A clear and a new error in the same cycle. A design where the clear wins loses the bit.
- Writes of ones into the syndrome fields, and hardware-corrected repeats. A design that lets software write the syndromes, or that sets the multiple-error flag for corrected errors, is caught here.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
    localparam int REG_W    = 64;
    localparam int NUM_CLS  = 19;
    localparam int CLS_W    = $clog2(NUM_CLS);
    localparam int STK_LO   = 33;
    localparam int BIT_PRIV = STK_LO + NUM_CLS;
    localparam int BIT_ME   = BIT_PRIV + 1;
    localparam int MSYN_LO  = 16;
    localparam int MSYN_W   = 4;
    localparam int DSYN_W   = 9;

    typedef enum logic [1:0] {
        RANK_HWC   = 2'd0,
        RANK_SWC   = 2'd1,
        RANK_UNC   = 2'd2,
        RANK_FATAL = 2'd3
    } rank_e;

    function automatic rank_e cls_rank(input logic [CLS_W-1:0] c);
        case (c)
            5'd17, 5'd18:                         return RANK_FATAL;
            5'd9:                                 return RANK_SWC;
            5'd0, 5'd3, 5'd5, 5'd7, 5'd13, 5'd15: return RANK_HWC;
            default:                              return RANK_UNC;
        endcase
    endfunction

    typedef struct packed {
        logic [REG_W-1:0] word;
    } stat_t;
endpackage

// File: rtl/fsl_beat_filter.sv
module fsl_beat_filter #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              err_valid,
    input  logic              cls_ok,
    input  logic              err_ecc,
    input  logic [BEAT_W-1:0] err_beat,
    output logic              accept
);
    typedef struct packed {
        logic              seen;
        logic [BEAT_W-1:0] beat;
    } filt_t;

    filt_t filt_d, filt_q;
    logic  seen_eff;
    logic  late;

    always_comb begin
        filt_d   = filt_q;
        seen_eff = filt_q.seen & ~txn_start;
        late     = err_ecc & seen_eff & (err_beat > filt_q.beat);
        accept   = err_valid & cls_ok & ~late;
        if (txn_start) filt_d.seen = 1'b0;
        if (accept && err_ecc && !seen_eff) begin
            filt_d.seen = 1'b1;
            filt_d.beat = err_beat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_q <= '0;
        else        filt_q <= filt_d;
    end
endmodule

// File: rtl/fsl_capture.sv
module fsl_capture import fsl_pkg::*; #(
    parameter int ADDR_W = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [CLS_W-1:0]   cls,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [MSYN_W-1:0]  msyn,
    input  logic [DSYN_W-1:0]  dsyn,
    input  logic [NUM_CLS-1:0] clr_mask,
    output logic [ADDR_W-1:0]  cap_addr,
    output logic [MSYN_W-1:0]  cap_msyn,
    output logic [DSYN_W-1:0]  cap_dsyn
);
    typedef struct packed {
        logic              valid;
        logic [CLS_W-1:0]  owner;
        logic [ADDR_W-1:0] addr;
        logic [MSYN_W-1:0] msyn;
        logic [DSYN_W-1:0] dsyn;
    } cap_t;

    cap_t cap_d, cap_q;
    logic held;
    logic take;

    always_comb begin
        cap_d = cap_q;
        held  = cap_q.valid & ~clr_mask[cap_q.owner];
        take  = accept & (~held | (cls_rank(cls) > cls_rank(cap_q.owner)));
        if (take) begin
            cap_d.valid = 1'b1;
            cap_d.owner = cls;
            cap_d.addr  = addr;
            cap_d.msyn  = msyn;
            cap_d.dsyn  = dsyn;
        end else if (!held) begin
            cap_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap_addr = cap_q.addr;
    assign cap_msyn = cap_q.msyn;
    assign cap_dsyn = cap_q.dsyn;
endmodule

// File: rtl/fault_status_log.sv
module fault_status_log import fsl_pkg::*; #(
    parameter int ADDR_W = 40,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_valid,
    input  logic [CLS_W-1:0]  err_class,
    input  logic              err_ecc,
    input  logic [BEAT_W-1:0] err_beat,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [MSYN_W-1:0] err_msyn,
    input  logic [DSYN_W-1:0] err_dsyn,
    input  logic              err_priv,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              irq_en,
    output logic              irq,
    output logic              fatal_err
);
    localparam logic [REG_W-1:0] W1C_MASK =
        ((REG_W'(1) << (NUM_CLS + 2)) - REG_W'(1)) << STK_LO;

    stat_t              stat_d, stat_q;
    logic               cls_ok;
    logic               accept;
    logic               wr_stat;
    logic [REG_W-1:0]   clr_word;
    logic [REG_W-1:0]   set_word;
    logic [NUM_CLS-1:0] hit_vec;
    logic [REG_W-1:0]   stat_view;
    logic [ADDR_W-1:0]  cap_addr;
    logic [MSYN_W-1:0]  cap_msyn;
    logic [DSYN_W-1:0]  cap_dsyn;

    assign cls_ok   = (err_class < CLS_W'(NUM_CLS));
    assign wr_stat  = reg_wr & ~reg_addr;
    assign clr_word = wr_stat ? (reg_wdata & W1C_MASK) : '0;
    assign hit_vec  = NUM_CLS'(1) << err_class;

    fsl_beat_filter #(.BEAT_W(BEAT_W)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .txn_start (txn_start),
        .err_valid (err_valid),
        .cls_ok    (cls_ok),
        .err_ecc   (err_ecc),
        .err_beat  (err_beat),
        .accept    (accept)
    );

    fsl_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .cls      (err_class),
        .addr     (err_addr),
        .msyn     (err_msyn),
        .dsyn     (err_dsyn),
        .clr_mask (clr_word[STK_LO +: NUM_CLS]),
        .cap_addr (cap_addr),
        .cap_msyn (cap_msyn),
        .cap_dsyn (cap_dsyn)
    );

    always_comb begin
        stat_d   = stat_q;
        set_word = '0;
        if (accept) begin
            set_word[STK_LO +: NUM_CLS] = hit_vec;
            if ((cls_rank(err_class) != RANK_HWC) &&
                (|(stat_q.word[STK_LO +: NUM_CLS] & hit_vec)))
                set_word[BIT_ME] = 1'b1;
        end
        // New events take precedence over a clear in the same cycle.
        stat_d.word = (stat_q.word & ~clr_word) | set_word;
        if (accept) stat_d.word[BIT_PRIV] = err_priv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    always_comb begin
        stat_view = stat_q.word;
        stat_view[MSYN_LO +: MSYN_W] = cap_msyn;
        stat_view[DSYN_W-1:0]        = cap_dsyn;
    end

    assign reg_rdata = reg_addr ? REG_W'(cap_addr) : stat_view;
    assign irq       = irq_en & (|stat_q.word[STK_LO +: NUM_CLS-1]);
    assign fatal_err = stat_q.word[STK_LO+NUM_CLS-1] | stat_q.word[STK_LO+NUM_CLS-2];
endmodule

// File: rtl/fsl_checker.sv
module fsl_checker import fsl_pkg::*; #(
    parameter int ADDR_W = 40
) (
    input logic               clk,
    input logic               rst_n,
    input logic               err_valid,
    input logic [CLS_W-1:0]   err_class,
    input logic               err_ecc,
    input logic               reg_wr,
    input logic               reg_addr,
    input logic               irq_en,
    input logic               irq,
    input logic               fatal_err,
    input logic [NUM_CLS-1:0] rd_err,
    input logic [NUM_CLS-1:0] stk_q,
    input logic               me_q,
    input logic [ADDR_W-1:0]  cap_addr
);
    AST_FATAL_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b0) |-> (fatal_err == (rd_err[NUM_CLS-1] | rd_err[NUM_CLS-2])));  // R9

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b0) |-> (irq == (irq_en & (|rd_err[NUM_CLS-2:0]))));  // R10

    AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 1'b0) |=> (($past(stk_q) & ~stk_q) == '0));  // R2

    AST_HWC_NO_ME: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && cls_rank(err_class) == RANK_HWC && !me_q) |=> !me_q);  // R3

    AST_NEW_ERROR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_class < CLS_W'(NUM_CLS) && !err_ecc) |=> stk_q[$past(err_class)]);  // R11

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> $stable(cap_addr));  // R6
endmodule

bind fault_status_log fsl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_valid (err_valid),
    .err_class (err_class),
    .err_ecc   (err_ecc),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .irq_en    (irq_en),
    .irq       (irq),
    .fatal_err (fatal_err),
    .rd_err    (reg_rdata[51:33]),
    .stk_q     (stat_q.word[51:33]),
    .me_q      (stat_q.word[53]),
    .cap_addr  (cap_addr)
);

// File: tb/fault_status_log_test.sv
`timescale 1ns/1ps
module fault_status_log_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_valid = 1'b0;
    logic [4:0]  err_class = '0;
    logic        err_ecc = 1'b0;
    logic [1:0]  err_beat = '0;
    logic        txn_start = 1'b0;
    logic [39:0] err_addr = '0;
    logic [3:0]  err_msyn = '0;
    logic [8:0]  err_dsyn = '0;
    logic        err_priv = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq_en = 1'b1;
    logic        irq;
    logic        fatal_err;

    int total = 0;
    int bad = 0;
    bit live = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fault_status_log uut (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_class(err_class),
        .err_ecc(err_ecc), .err_beat(err_beat), .txn_start(txn_start),
        .err_addr(err_addr), .err_msyn(err_msyn), .err_dsyn(err_dsyn),
        .err_priv(err_priv), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_en(irq_en),
        .irq(irq), .fatal_err(fatal_err)
    );

    // ---------------- behavioural reference model ----------------
    bit [18:0]   m_stk;
    bit          m_me, m_pv;
    logic [39:0] m_a;
    bit [3:0]    m_ms;
    bit [8:0]    m_ds;
    int          m_own;
    bit          m_seen;
    int          m_beat;

    function automatic int rk(int c);
        if (c == 17 || c == 18) return 3;
        if (c == 9) return 1;
        if (c == 0 || c == 3 || c == 5 || c == 7 || c == 13 || c == 15) return 0;
        return 2;
    endfunction

    function automatic logic [63:0] m_word();
        logic [63:0] w = '0;
        w[53] = m_me;
        w[52] = m_pv;
        for (int k = 0; k < 19; k++) w[33+k] = m_stk[k];
        w[19:16] = m_ms;
        w[8:0] = m_ds;
        return w;
    endfunction

    always @(posedge clk) begin
        logic [63:0] clr;
        bit acc, old, held;
        int c;
        if (!rst_n) begin
            m_stk = '0; m_me = 0; m_pv = 0; m_a = '0; m_ms = '0; m_ds = '0;
            m_own = -1; m_seen = 0; m_beat = 0;
        end else begin
            c = int'(err_class);
            clr = (reg_wr && !reg_addr) ? reg_wdata : 64'd0;
            if (txn_start) m_seen = 0;
            acc = err_valid && c < 19;
            if (acc && err_ecc && m_seen && int'(err_beat) > m_beat) acc = 0;
            if (acc && err_ecc && !m_seen) begin m_seen = 1; m_beat = int'(err_beat); end
            held = (m_own >= 0) && !clr[33+m_own];
            old = acc ? m_stk[c] : 1'b0;
            for (int k = 0; k < 19; k++) if (clr[33+k]) m_stk[k] = 0;
            if (clr[52]) m_pv = 0;
            if (clr[53]) m_me = 0;
            if (acc) begin
                m_stk[c] = 1;
                if (rk(c) > 0 && old) m_me = 1;
                m_pv = err_priv;
            end
            if (acc && (!held || rk(c) > rk(m_own))) begin
                m_own = c; m_a = err_addr; m_ms = err_msyn; m_ds = err_dsyn;
            end else if (!held) begin
                m_own = -1;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always begin
        @(negedge clk);
        #2;
        if (live) begin
            logic [63:0] e;
            e = reg_addr ? {24'd0, m_a} : m_word();
            total++;
            if (reg_rdata !== e) begin
                bad++;
                $display("FAIL R1 model read addr=%0d act=%h exp=%h", reg_addr, reg_rdata, e);
            end
            total++;
            if (irq !== (irq_en && (|m_stk[17:0]))) begin
                bad++;
                $display("FAIL R10 model irq act=%b exp=%b", irq, irq_en && (|m_stk[17:0]));
            end
            total++;
            if (fatal_err !== (m_stk[18] | m_stk[17])) begin
                bad++;
                $display("FAIL R9 model fatal act=%b exp=%b", fatal_err, m_stk[18] | m_stk[17]);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input bit v, input int cls, input bit ecc, input int beat, input bit txn,
                        input logic [39:0] a, input logic [3:0] ms, input logic [8:0] ds,
                        input bit pv, input bit wr, input bit ra, input logic [63:0] wd);
        @(negedge clk);
        err_valid = v; err_class = 5'(cls); err_ecc = ecc; err_beat = 2'(beat);
        txn_start = txn; err_addr = a; err_msyn = ms; err_dsyn = ds; err_priv = pv;
        reg_wr = wr; reg_addr = ra; reg_wdata = wd;
    endtask

    task automatic err(input int cls, input bit ecc, input int beat, input bit txn,
                       input logic [39:0] a, input logic [3:0] ms, input logic [8:0] ds, input bit pv);
        step(1, cls, ecc, beat, txn, a, ms, ds, pv, 0, 0, 64'd0);
    endtask

    task automatic wr(input bit ra, input logic [63:0] wd);
        step(0, 0, 0, 0, 0, 40'd0, 4'd0, 9'd0, 0, 1, ra, wd);
    endtask

    task automatic peek(input bit ra, output logic [63:0] v);
        step(0, 0, 0, 0, 0, 40'd0, 4'd0, 9'd0, 0, 0, ra, 64'd0);
        #2;
        v = reg_rdata;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] b(int k);
        return 64'd1 << (33 + k);
    endfunction

    function automatic logic [63:0] syn(logic [3:0] ms, logic [8:0] ds);
        return (64'(ms) << 16) | 64'(ds);
    endfunction

    localparam logic [63:0] ME = 64'd1 << 53;
    localparam logic [63:0] PV = 64'd1 << 52;

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [63:0] v, v2;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        live = 1;

        // R12 reset state
        peek(0, v); chk("R12 reset status", v, 64'd0);
        chk("R12 reset irq/fatal", {62'd0, irq, fatal_err}, 64'd0);
        peek(1, v); chk("R12 reset address", v, 64'd0);

        // R1, R8, R10: first corrected error
        err(0, 0, 0, 0, 40'h10, 4'h3, 9'h0A5, 0);
        peek(0, v); chk("R1 corrected bit set", v, b(0) | syn(4'h3, 9'h0A5));
        chk("R10 irq raised", {63'd0, irq}, 64'd1);
        peek(1, v); chk("R8 address read", v, 64'h10);

        // R3, R6: corrected repeat, no ME, equal rank keeps capture
        err(0, 0, 0, 0, 40'h20, 4'h5, 9'h001, 0);
        peek(0, v); chk("R3 hw-corrected repeat no ME", v, b(0) | syn(4'h3, 9'h0A5));

        // R6: uncorrectable overwrites
        err(1, 0, 0, 0, 40'h30, 4'h6, 9'h111, 0);
        peek(1, v); chk("R6 higher rank overwrites", v, 64'h30);

        // R6: lower rank does not
        err(0, 0, 0, 0, 40'h40, 4'h7, 9'h007, 0);
        peek(1, v); chk("R6 lower rank kept out", v, 64'h30);

        // R3: uncorrectable repeat sets ME; equal rank keeps address
        err(1, 0, 0, 0, 40'h50, 4'h8, 9'h002, 0);
        peek(0, v); chk("R3 ME on repeat", v, ME | b(0) | b(1) | syn(4'h6, 9'h111));
        peek(1, v); chk("R6 equal rank keeps", v, 64'h30);

        // R2: reads do not clear
        peek(0, v); peek(0, v2); chk("R2 read keeps bits", v2, v);

        // R1: clear only bit 33; owner not affected
        wr(0, b(0));
        peek(0, v); chk("R1 W1C single bit", v, ME | b(1) | syn(4'h6, 9'h111));
        wr(0, 64'd0);
        peek(0, v); chk("R1 write zero no effect", v, ME | b(1) | syn(4'h6, 9'h111));

        // R7: unlock while another bit stays set
        err(0, 0, 0, 0, 40'h60, 4'h1, 9'h033, 0);
        wr(0, b(1));
        peek(1, v); chk("R7 held value readable", v, 64'h30);
        err(0, 0, 0, 0, 40'h70, 4'h2, 9'h044, 0);
        peek(1, v); chk("R7 capture after unlock", v, 64'h70);
        peek(0, v); chk("R7 status after unlock", v, ME | b(0) | syn(4'h2, 9'h044));

        // R8: syndromes and address are read-only
        wr(0, 64'h000F_01FF);
        peek(0, v); chk("R8 syndrome write ignored", v, ME | b(0) | syn(4'h2, 9'h044));
        wr(1, '1);
        peek(1, v); chk("R8 address write ignored", v, 64'h70);

        // R10: clear everything drops irq
        wr(0, '1);
        peek(0, v); chk("R1 clear all", v, syn(4'h2, 9'h044));
        chk("R10 irq drops", {63'd0, irq}, 64'd0);

        // R9: fatal errors
        err(18, 0, 0, 0, 40'h80, 4'h9, 9'h1FF, 0);
        peek(0, v); chk("R9 fatal bit", v, b(18) | syn(4'h9, 9'h1FF));
        chk("R9 fatal pin high", {63'd0, fatal_err}, 64'd1);
        chk("R10 bit 51 alone no irq", {63'd0, irq}, 64'd0);
        err(17, 0, 0, 0, 40'h90, 4'hA, 9'h0F0, 0);
        peek(1, v); chk("R6 equal fatal keeps", v, 64'h80);
        wr(0, b(18));
        peek(0, v); chk("R9 fatal from bit 50", {63'd0, fatal_err}, 64'd1);
        wr(0, b(17));
        peek(0, v); chk("R9 fatal pin low", {63'd0, fatal_err}, 64'd0);

        // R5: privilege capture, R3 software-correctable repeat
        err(9, 0, 0, 0, 40'hA0, 4'hB, 9'h0C3, 1);
        peek(0, v); chk("R5 priv captured", v, PV | b(9) | syn(4'hB, 9'h0C3));
        err(9, 0, 0, 0, 40'hB0, 4'hC, 9'h0D4, 0);
        peek(0, v); chk("R5 priv follows latest, R3 ME", v, ME | b(9) | syn(4'hB, 9'h0C3));
        wr(0, '1);

        // R4: beat filter
        err(1, 1, 1, 1, 40'hC0, 4'h1, 9'h011, 0);
        err(3, 1, 2, 0, 40'hD0, 4'h4, 9'h01E, 0);
        peek(0, v); chk("R4 later beat dropped", v, b(1) | syn(4'h1, 9'h011));
        err(1, 1, 3, 0, 40'hD8, 4'h4, 9'h01E, 0);
        peek(0, v); chk("R4 dropped error sets no ME", v, b(1) | syn(4'h1, 9'h011));
        err(3, 1, 2, 1, 40'hE0, 4'h4, 9'h01E, 0);
        peek(0, v); chk("R4 new transaction accepted", v, b(1) | b(3) | syn(4'h1, 9'h011));
        peek(1, v); chk("R4 lower rank no capture", v, 64'hC0);

        // R11: clear and new error on the same bit
        step(1, 1, 0, 0, 0, 40'hF0, 4'h5, 9'h055, 0, 1, 0, b(1));
        peek(0, v); chk("R11 new error wins", v, ME | b(1) | b(3) | syn(4'h5, 9'h055));
        peek(1, v); chk("R11 capture after unlock", v, 64'hF0);

        // R10: enable gating
        @(negedge clk) irq_en = 1'b0;
        peek(0, v); chk("R10 irq gated off", {63'd0, irq}, 64'd0);
        @(negedge clk) irq_en = 1'b1;

        // R12: invalid class ignored
        err(20, 0, 0, 0, 40'h1234, 4'hF, 9'h1AB, 1);
        peek(0, v); chk("R12 invalid class ignored", v, ME | b(1) | b(3) | syn(4'h5, 9'h055));

        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule